// File: doc/BRIEF.md
# Configurable Serial Receive Front-End

This block turns an asynchronous serial line into received words. A baud-rate tick, one clock-wide pulse at the oversampling rate, arrives as an input, and the block counts these ticks to locate the bit centres. Run-time inputs select the frame shape: 16 or 8 ticks per bit, start recognition on a low level or on a high-to-low transition, least- or most-significant bit first, 8 or 9 data bits, no/even/odd parity, and one or two stop bits. An optional three-sample majority vote rejects single-tick glitches on the line.

A completed frame is placed in a data register that raises a full flag until the consumer pulses the read strobe. Parity, framing and overrun problems are latched in sticky flags, and each flag has its own clear strobe. An idle timeout, when enabled, raises a flag once the line has stayed quiet for a programmed number of bit times after the end of a frame.

Top module: `uart_rx_frontend`

## Requirements
- R1: After reset the data output is 0 and the full, parity, framing, overrun and timeout flags are all 0.
- R2: With 16 or 8 ticks per bit, a frame of a start bit (0), data, and a stop bit (1) puts the data word on `rxData` (upper bit 0 for 8-bit words) and raises `rxFull`, with no error flag set.
- R3: With `cfgMsbFirst` = 1 the first data bit on the line is the most significant bit of the word; with 0 it is the least significant.
- R4: With `cfgNineBit` = 1 the data field is 9 bits and all 9 appear on `rxData`.
- R5: With parity enabled, the parity bit follows the data; even mode (`cfgParityOdd` = 0) expects the count of ones over data and parity to be even, odd mode expects it odd. A mismatch sets `errParity`, and the word is still stored.
- R6: A stop bit sampled as 0 sets `errFraming`; with two stop bits a 0 in either one sets it.
- R7: A frame that completes while `rxFull` is 1 and no read strobe is present sets `errOverrun`; `rxData` keeps the older word and the new one is dropped.
- R8: A pulse on `rdStrobe` clears `rxFull`.
- R9: Each clear strobe clears only its own sticky flag.
- R10: With the filter enabled a bit is the majority of the samples at tick positions 7, 8, 9 of 16 (3, 4, 5 of 8); with it disabled only position 8 (or 4) counts.
- R11: With `cfgEdgeStart` = 0 any low sample on an idle line starts a frame; with 1 a frame starts only where a high sample is followed by a low one. A start bit that reads high at its decision point is abandoned without a frame.
- R12: With the timeout enabled, `flagTimeout` rises after `cfgTimeoutBits` bit times of idle ticks following the last frame, and does not rise again until another frame has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle pulse at the oversampling rate |
| rxPin | input | 1 | Serial line, idle high |
| cfgOver8 | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| cfgEdgeStart | input | 1 | 1: start on high-to-low transition, 0: start on low level |
| cfgMsbFirst | input | 1 | 1: most significant bit first |
| cfgNineBit | input | 1 | 1: 9 data bits, 0: 8 data bits |
| cfgParityEn | input | 1 | Parity bit present and checked |
| cfgParityOdd | input | 1 | 1: odd parity, 0: even parity |
| cfgTwoStop | input | 1 | 1: two stop bits |
| cfgFilterEn | input | 1 | Enable three-sample majority vote |
| cfgTimeoutEn | input | 1 | Enable the idle timeout |
| cfgTimeoutBits | input | 8 | Idle bit times before the timeout flag |
| rdStrobe | input | 1 | Consumer has taken the data word |
| clrParity | input | 1 | Clear the parity error flag |
| clrFraming | input | 1 | Clear the framing error flag |
| clrOverrun | input | 1 | Clear the overrun flag |
| clrTimeout | input | 1 | Clear the timeout flag |
| rxData | output | 9 | Received word |
| rxFull | output | 1 | Data register holds an unread word |
| errParity | output | 1 | Sticky parity error |
| errFraming | output | 1 | Sticky framing error |
| errOverrun | output | 1 | Sticky overrun |
| flagTimeout | output | 1 | Sticky idle timeout |

## Verification
The hardest conditions to reach are those that depend on where within a bit the line changes: a one-tick glitch must land exactly on a voting position, and the start-recognition modes only differ when the line stays low past the end of a frame. The bench aligns every line change to the tick just consumed, so it can invert a single chosen sample of a chosen bit, and it holds the line low for many bit times after a frame with a low stop bit so that level-mode restarts pile up into an overrun while transition mode stays silent.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_FRAME = 1'b1
  } rxState_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic frameDone;  // one clock: rxWord and error bits are valid
    logic parityBad;
    logic stopBad;
    logic busy;       // a frame is being sampled
  } rxStrobes_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
`timescale 1ns/1ps
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              rxPin,
  input  logic              cfgOver8,
  input  logic              cfgEdgeStart,
  input  logic              cfgMsbFirst,
  input  logic              cfgNineBit,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic              cfgFilterEn,
  output rxStrobes_t        strb,
  output logic [DATA_W-1:0] rxWord
);

  localparam int IDX_W = $clog2(DATA_W + 4);
  localparam int PH_W  = 4;

  rxState_e          state;
  logic [1:0]        syncQ;
  logic              rxS;
  logic              prevS;
  logic [PH_W-1:0]   phase;
  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] shreg;
  logic              sLo, sMid, parBit, stopAcc;
  logic              doneQ, parBadQ, stopBadQ;

  logic [PH_W-1:0]   phLo, phMid, phHi, phLast;
  logic [IDX_W-1:0]  dataLen, parIdx, lastIdx;
  logic              vote, startSeen;
  logic [DATA_W-1:0] wordNow;
  logic              parityBad;

  // two-flop synchroniser on the line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxPin};
  end
  assign rxS = syncQ[1];

  // sample positions around the bit centre
  always_comb begin
    phLo   = cfgOver8 ? PH_W'(3) : PH_W'(7);
    phMid  = cfgOver8 ? PH_W'(4) : PH_W'(8);
    phHi   = cfgOver8 ? PH_W'(5) : PH_W'(9);
    phLast = cfgOver8 ? PH_W'(7) : PH_W'(15);
  end

  always_comb begin
    dataLen = cfgNineBit ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
    parIdx  = dataLen + IDX_W'(1);
    lastIdx = dataLen + IDX_W'(cfgParityEn) + (cfgTwoStop ? IDX_W'(2) : IDX_W'(1));
  end

  // majority of three, or centre sample alone
  assign vote = cfgFilterEn ? ((sLo & sMid) | (sLo & rxS) | (sMid & rxS)) : sMid;

  assign startSeen = cfgEdgeStart ? (prevS & ~rxS) : ~rxS;

  // word alignment for the shorter data field
  always_comb begin
    if (cfgNineBit)       wordNow = shreg;
    else if (cfgMsbFirst) wordNow = {1'b0, shreg[DATA_W-2:0]};
    else                  wordNow = {1'b0, shreg[DATA_W-1:1]};
  end

  assign parityBad = cfgParityEn & (^wordNow ^ parBit ^ cfgParityOdd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      prevS    <= 1'b1;
      phase    <= '0;
      bitIdx   <= '0;
      shreg    <= '0;
      sLo      <= 1'b1;
      sMid     <= 1'b1;
      parBit   <= 1'b0;
      stopAcc  <= 1'b0;
      doneQ    <= 1'b0;
      parBadQ  <= 1'b0;
      stopBadQ <= 1'b0;
      rxWord   <= '0;
    end else begin
      doneQ <= 1'b0;
      if (baudTick) begin
        prevS <= rxS;
        unique case (state)
          RX_IDLE: begin
            if (startSeen) begin
              state   <= RX_FRAME;
              phase   <= PH_W'(1);
              bitIdx  <= '0;
              shreg   <= '0;
              parBit  <= 1'b0;
              stopAcc <= 1'b0;
            end
          end
          RX_FRAME: begin
            if (phase == phLo)  sLo  <= rxS;
            if (phase == phMid) sMid <= rxS;
            if (phase == phLast) begin
              phase  <= '0;
              bitIdx <= bitIdx + IDX_W'(1);
            end else begin
              phase <= phase + PH_W'(1);
            end
            if (phase == phHi) begin
              if (bitIdx == '0) begin
                if (vote) state <= RX_IDLE;  // start bit not confirmed
              end else if (bitIdx <= dataLen) begin
                if (cfgMsbFirst) shreg <= {shreg[DATA_W-2:0], vote};
                else             shreg <= {vote, shreg[DATA_W-1:1]};
              end else if (cfgParityEn && (bitIdx == parIdx)) begin
                parBit <= vote;
              end else if (bitIdx == lastIdx) begin
                doneQ    <= 1'b1;
                stopBadQ <= stopAcc | ~vote;
                parBadQ  <= parityBad;
                rxWord   <= wordNow;
                state    <= RX_IDLE;
              end else begin
                stopAcc <= stopAcc | ~vote;
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strb.frameDone = doneQ;
    strb.parityBad = parBadQ;
    strb.stopBad   = stopBadQ;
    strb.busy      = (state == RX_FRAME);
  end

endmodule

// File: rtl/uart_rx_dpath.sv
`timescale 1ns/1ps
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int TO_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              cfgOver8,
  input  logic              cfgTimeoutEn,
  input  logic [TO_W-1:0]   cfgTimeoutBits,
  input  rxStrobes_t        strb,
  input  logic [DATA_W-1:0] word,
  input  logic              rdStrobe,
  input  logic              clrParity,
  input  logic              clrFraming,
  input  logic              clrOverrun,
  input  logic              clrTimeout,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              errParity,
  output logic              errFraming,
  output logic              errOverrun,
  output logic              flagTimeout
);

  localparam int CNT_W = TO_W + 4;

  logic             loadOk, dropNew;
  logic [CNT_W-1:0] toCnt, toTarget;
  logic             toArmed, toFire;

  assign loadOk  = strb.frameDone & (~rxFull | rdStrobe);
  assign dropNew = strb.frameDone & rxFull & ~rdStrobe;

  assign toTarget = cfgOver8 ? {1'b0, cfgTimeoutBits, 3'b000} : {cfgTimeoutBits, 4'b0000};
  assign toFire   = toArmed & cfgTimeoutEn & baudTick & ~strb.busy & ~strb.frameDone &
                    (toTarget != '0) & ((toCnt + CNT_W'(1)) == toTarget);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxFull <= 1'b0;
    end else if (loadOk) begin
      rxData <= word;
      rxFull <= 1'b1;
    end else if (rdStrobe) begin
      rxFull <= 1'b0;
    end
  end

  // sticky flags: a set in the same cycle wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errParity   <= 1'b0;
      errFraming  <= 1'b0;
      errOverrun  <= 1'b0;
      flagTimeout <= 1'b0;
    end else begin
      if (loadOk && strb.parityBad) errParity <= 1'b1;
      else if (clrParity)           errParity <= 1'b0;
      if (loadOk && strb.stopBad)   errFraming <= 1'b1;
      else if (clrFraming)          errFraming <= 1'b0;
      if (dropNew)                  errOverrun <= 1'b1;
      else if (clrOverrun)          errOverrun <= 1'b0;
      if (toFire)                   flagTimeout <= 1'b1;
      else if (clrTimeout)          flagTimeout <= 1'b0;
    end
  end

  // idle timer, armed by each completed frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toArmed <= 1'b0;
      toCnt   <= '0;
    end else if (strb.frameDone) begin
      toArmed <= 1'b1;
      toCnt   <= '0;
    end else if (strb.busy) begin
      toCnt <= '0;
    end else if (toFire) begin
      toArmed <= 1'b0;
      toCnt   <= '0;
    end else if (toArmed && cfgTimeoutEn && baudTick) begin
      toCnt <= toCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/uart_rx_frontend.sv
`timescale 1ns/1ps
module uart_rx_frontend
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int TO_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              rxPin,
  input  logic              cfgOver8,
  input  logic              cfgEdgeStart,
  input  logic              cfgMsbFirst,
  input  logic              cfgNineBit,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic              cfgFilterEn,
  input  logic              cfgTimeoutEn,
  input  logic [TO_W-1:0]   cfgTimeoutBits,
  input  logic              rdStrobe,
  input  logic              clrParity,
  input  logic              clrFraming,
  input  logic              clrOverrun,
  input  logic              clrTimeout,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              errParity,
  output logic              errFraming,
  output logic              errOverrun,
  output logic              flagTimeout
);

  rxStrobes_t        strb;
  logic [DATA_W-1:0] word;

  uart_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .baudTick     (baudTick),
    .rxPin        (rxPin),
    .cfgOver8     (cfgOver8),
    .cfgEdgeStart (cfgEdgeStart),
    .cfgMsbFirst  (cfgMsbFirst),
    .cfgNineBit   (cfgNineBit),
    .cfgParityEn  (cfgParityEn),
    .cfgParityOdd (cfgParityOdd),
    .cfgTwoStop   (cfgTwoStop),
    .cfgFilterEn  (cfgFilterEn),
    .strb         (strb),
    .rxWord       (word)
  );

  uart_rx_dpath #(.DATA_W(DATA_W), .TO_W(TO_W)) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .baudTick       (baudTick),
    .cfgOver8       (cfgOver8),
    .cfgTimeoutEn   (cfgTimeoutEn),
    .cfgTimeoutBits (cfgTimeoutBits),
    .strb           (strb),
    .word           (word),
    .rdStrobe       (rdStrobe),
    .clrParity      (clrParity),
    .clrFraming     (clrFraming),
    .clrOverrun     (clrOverrun),
    .clrTimeout     (clrTimeout),
    .rxData         (rxData),
    .rxFull         (rxFull),
    .errParity      (errParity),
    .errFraming     (errFraming),
    .errOverrun     (errOverrun),
    .flagTimeout    (flagTimeout)
  );

endmodule

// File: rtl/uart_rx_frontend_chk.sv
`timescale 1ns/1ps
module uart_rx_frontend_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStrobe,
  input logic              clrParity,
  input logic              rxFull,
  input logic [DATA_W-1:0] rxData,
  input logic              errParity,
  input logic              errOverrun,
  input logic              flagTimeout,
  input logic              frameDone,
  input logic              busy
);

  a_r8_read_empties: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !frameDone) |=> !rxFull);

  a_r7_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errOverrun) |-> $stable(rxData));

  a_r9_clear_parity: assert property (@(posedge clk) disable iff (!rstN)
    (clrParity && !frameDone) |=> !errParity);

  a_r2_data_from_frame: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> $past(frameDone));

  a_r5_parity_from_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errParity) |-> $past(frameDone));

  a_r12_timeout_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagTimeout) |-> $past(!busy));

endmodule

bind uart_rx_frontend uart_rx_frontend_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rdStrobe    (rdStrobe),
  .clrParity   (clrParity),
  .rxFull      (rxFull),
  .rxData      (rxData),
  .errParity   (errParity),
  .errOverrun  (errOverrun),
  .flagTimeout (flagTimeout),
  .frameDone   (strb.frameDone),
  .busy        (strb.busy)
);

// File: tb/sim_uart_rx_frontend.sv
`timescale 1ns/1ps
module sim_uart_rx_frontend;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] tickCnt = 2'd0;
  logic baudTick;
  logic rxPin = 1'b1;
  logic cfgOver8, cfgEdgeStart, cfgMsbFirst, cfgNineBit, cfgParityEn, cfgParityOdd;
  logic cfgTwoStop, cfgFilterEn, cfgTimeoutEn;
  logic [7:0] cfgTimeoutBits;
  logic rdStrobe = 1'b0, clrParity = 1'b0, clrFraming = 1'b0, clrOverrun = 1'b0, clrTimeout = 1'b0;
  logic [8:0] rxData;
  logic rxFull, errParity, errFraming, errOverrun, flagTimeout;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  always_ff @(posedge clk) tickCnt <= tickCnt + 2'd1;
  assign baudTick = (tickCnt == 2'd3);

  uart_rx_frontend u0 (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxPin(rxPin),
    .cfgOver8(cfgOver8), .cfgEdgeStart(cfgEdgeStart), .cfgMsbFirst(cfgMsbFirst),
    .cfgNineBit(cfgNineBit), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .cfgTwoStop(cfgTwoStop), .cfgFilterEn(cfgFilterEn), .cfgTimeoutEn(cfgTimeoutEn),
    .cfgTimeoutBits(cfgTimeoutBits), .rdStrobe(rdStrobe), .clrParity(clrParity),
    .clrFraming(clrFraming), .clrOverrun(clrOverrun), .clrTimeout(clrTimeout),
    .rxData(rxData), .rxFull(rxFull), .errParity(errParity), .errFraming(errFraming),
    .errOverrun(errOverrun), .flagTimeout(flagTimeout)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitTick();
    do @(negedge clk); while (baudTick !== 1'b1);
    @(posedge clk);
    #1;
  endtask

  task automatic driveSample(input logic v);
    rxPin = v;
    waitTick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) driveSample(1'b1);
  endtask

  task automatic defaults();
    cfgOver8 = 0; cfgEdgeStart = 0; cfgMsbFirst = 0; cfgNineBit = 0;
    cfgParityEn = 0; cfgParityOdd = 0; cfgTwoStop = 0; cfgFilterEn = 0;
    cfgTimeoutEn = 0; cfgTimeoutBits = 8'd0;
  endtask

  task automatic pulse(input bit rd, input bit cp, input bit cf, input bit co, input bit ct);
    @(posedge clk); #1;
    rdStrobe = rd; clrParity = cp; clrFraming = cf; clrOverrun = co; clrTimeout = ct;
    @(posedge clk); #1;
    rdStrobe = 0; clrParity = 0; clrFraming = 0; clrOverrun = 0; clrTimeout = 0;
    @(posedge clk); #1;
  endtask

  task automatic cleanup();
    idle(40);
    pulse(1, 1, 1, 1, 1);
    defaults();
  endtask

  // one frame; gBit/gPos invert one chosen sample (gBit < 0: none)
  task automatic driveFrame(input logic [8:0] dat, input bit flipPar, input bit [1:0] stopLow,
                            input int gBit, input int gPos);
    logic fb[16];
    int nb, w, ns;
    logic p, v;
    w  = cfgNineBit ? 9 : 8;
    ns = cfgOver8 ? 8 : 16;
    fb[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < w; i++) begin
      fb[1+i] = cfgMsbFirst ? dat[w-1-i] : dat[i];
      p = p ^ dat[i];
    end
    nb = 1 + w;
    if (cfgParityEn) begin fb[nb] = p ^ cfgParityOdd ^ flipPar; nb++; end
    fb[nb] = ~stopLow[0]; nb++;
    if (cfgTwoStop) begin fb[nb] = ~stopLow[1]; nb++; end
    waitTick();
    for (int b = 0; b < nb; b++) begin
      for (int s = 0; s < ns; s++) begin
        v = fb[b];
        if (b == gBit && s == gPos) v = ~v;
        driveSample(v);
      end
    end
  endtask

  task automatic tReset();
    chk("R1 data", rxData, 9'h000);
    chk("R1 flags", {4'd0, rxFull, errParity, errFraming, errOverrun, flagTimeout}, 9'h000);
  endtask

  task automatic tBasic();
    driveFrame(9'h0A5, 0, 2'b00, -1, 0);
    chk("R2 x16 data", rxData, 9'h0A5);
    chk("R2 x16 full/errs", {5'd0, rxFull, errParity, errFraming, errOverrun}, 9'h008);
    pulse(1, 0, 0, 0, 0);
    chk("R8 read clears full", {8'd0, rxFull}, 9'h000);
    cleanup();
    cfgOver8 = 1;
    driveFrame(9'h03C, 0, 2'b00, -1, 0);
    chk("R2 x8 data", rxData, 9'h03C);
    chk("R2 x8 full", {8'd0, rxFull}, 9'h001);
    cleanup();
  endtask

  task automatic tOrder();
    cfgMsbFirst = 1;
    driveFrame(9'h01E, 0, 2'b00, -1, 0);
    chk("R3 msb first", rxData, 9'h01E);
    cleanup();
    cfgNineBit = 1;
    driveFrame(9'h1A7, 0, 2'b00, -1, 0);
    chk("R4 nine bit lsb", rxData, 9'h1A7);
    cleanup();
    cfgNineBit = 1; cfgMsbFirst = 1; cfgOver8 = 1;
    driveFrame(9'h1C3, 0, 2'b00, -1, 0);
    chk("R4 R3 nine bit msb", rxData, 9'h1C3);
    cleanup();
  endtask

  task automatic tParity();
    cfgParityEn = 1;
    driveFrame(9'h0B3, 0, 2'b00, -1, 0);
    chk("R5 even ok", {7'd0, rxFull, errParity}, 9'h002);
    cleanup();
    cfgParityEn = 1; cfgParityOdd = 1; cfgNineBit = 1;
    driveFrame(9'h101, 0, 2'b00, -1, 0);
    chk("R5 odd ok nine", {7'd0, rxFull, errParity}, 9'h002);
    cleanup();
    cfgParityEn = 1; cfgParityOdd = 1;
    driveFrame(9'h05A, 1, 2'b00, -1, 0);
    chk("R5 odd mismatch flag", {8'd0, errParity}, 9'h001);
    chk("R5 word still stored", rxData, 9'h05A);
    cleanup();
  endtask

  task automatic tFraming();
    driveFrame(9'h077, 0, 2'b01, -1, 0);
    idle(20);
    chk("R6 stop low", {8'd0, errFraming}, 9'h001);
    cleanup();
    cfgTwoStop = 1;
    driveFrame(9'h077, 0, 2'b00, -1, 0);
    chk("R6 two stops ok", {8'd0, errFraming}, 9'h000);
    cleanup();
    cfgTwoStop = 1;
    driveFrame(9'h077, 0, 2'b10, -1, 0);
    idle(20);
    chk("R6 second stop low", {8'd0, errFraming}, 9'h001);
    cleanup();
  endtask

  task automatic tOverrun();
    cfgParityEn = 1;
    driveFrame(9'h033, 1, 2'b00, -1, 0);
    driveFrame(9'h044, 0, 2'b00, -1, 0);
    chk("R7 overrun flag", {7'd0, errParity, errOverrun}, 9'h003);
    chk("R7 older word kept", rxData, 9'h033);
    pulse(0, 0, 0, 1, 0);
    chk("R9 clear overrun only", {7'd0, errParity, errOverrun}, 9'h002);
    pulse(0, 1, 0, 0, 0);
    chk("R9 clear parity", {7'd0, errParity, errOverrun}, 9'h000);
    chk("R9 full untouched by clears", {8'd0, rxFull}, 9'h001);
    cleanup();
  endtask

  task automatic tFilter();
    cfgFilterEn = 1;
    driveFrame(9'h0F0, 0, 2'b00, 1, 8);
    chk("R10 filter rejects glitch x16", rxData, 9'h0F0);
    cleanup();
    driveFrame(9'h0F0, 0, 2'b00, 1, 8);
    chk("R10 no filter centre glitch", rxData, 9'h0F1);
    cleanup();
    driveFrame(9'h0F0, 0, 2'b00, 1, 7);
    chk("R10 no filter off-centre ignored", rxData, 9'h0F0);
    cleanup();
    cfgFilterEn = 1; cfgOver8 = 1;
    driveFrame(9'h00F, 0, 2'b00, 8, 4);
    chk("R10 filter rejects glitch x8", rxData, 9'h00F);
    cleanup();
  endtask

  task automatic tStart();
    waitTick();
    for (int i = 0; i < 4; i++) driveSample(1'b0);
    idle(240);
    chk("R11 short low abandoned", {7'd0, rxFull, errFraming}, 9'h000);
    cleanup();
    cfgEdgeStart = 1;
    driveFrame(9'h000, 0, 2'b01, -1, 0);
    for (int i = 0; i < 640; i++) driveSample(1'b0);
    idle(240);
    chk("R11 edge mode one frame", {6'd0, rxFull, errFraming, errOverrun}, 9'h006);
    cleanup();
    driveFrame(9'h000, 0, 2'b01, -1, 0);
    for (int i = 0; i < 640; i++) driveSample(1'b0);
    idle(240);
    chk("R11 level mode restarts", {6'd0, rxFull, errFraming, errOverrun}, 9'h007);
    cleanup();
  endtask

  task automatic tTimeout();
    cfgTimeoutEn = 1; cfgTimeoutBits = 8'd3;
    driveFrame(9'h012, 0, 2'b00, -1, 0);
    idle(30);
    chk("R12 not before 3 bits", {8'd0, flagTimeout}, 9'h000);
    idle(20);
    chk("R12 after 3 bits", {8'd0, flagTimeout}, 9'h001);
    pulse(0, 0, 0, 0, 1);
    idle(100);
    chk("R12 no re-arm without frame", {8'd0, flagTimeout}, 9'h000);
    pulse(1, 0, 0, 0, 0);
    driveFrame(9'h013, 0, 2'b00, -1, 0);
    idle(50);
    chk("R12 re-armed by frame", {8'd0, flagTimeout}, 9'h001);
    cleanup();
  endtask

  initial begin
    defaults();
    repeat (5) @(posedge clk);
    #1;
    tReset();
    rstN = 1'b1;
    idle(4);
    tBasic();
    tOrder();
    tParity();
    tFraming();
    tOverrun();
    tFilter();
    tStart();
    tTimeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #1000000;
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule